// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a clocked host and an external 32K x 8 asynchronous static RAM. The host hands it one byte-wide read or write at a time. The controller then drives the memory's active-low chip select, read strobe and write strobe, the address bus, and a data bus that is split into an outgoing value, an enable and an incoming value. It returns read data with a one-cycle valid pulse.

Every analogue timing minimum is a parameter in nanoseconds. Each one is turned into a whole number of system clocks by rounding up, and every phase lasts at least one clock. The write window is the span in which chip select and write strobe are both low. The read strobe stays high for the whole of every write. The data driver is switched on only after the memory has had its bus-float time following a read, and it is released before any later read strobe can fall.

Back-pressure rules on the request side: a request is taken on a rising clock edge at which `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. It stays low from the accepting edge until the last recovery or turnaround clock of that access has ended. The request fields are sampled only on the accepting edge, and at every other time they are ignored. Read data has no back-pressure: `rd_valid` is a single-cycle pulse, and `rd_data` holds its value until the next capture.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are high, `sram_dq_oe` is low, `rd_valid` is low and `req_ready` is high.
- R2: `req_ready` is high exactly when the controller is idle. A request is accepted on an edge where `req_valid` and `req_ready` are both high. `req_write`=1 selects a write and `req_write`=0 selects a read.
- R3: A read holds chip select and read strobe low and the write strobe high for RD_CYC clocks, starting at the clock after acceptance. RD_CYC is the largest of ceil(70/P), ceil(70/P) and ceil(35/P) (14 at P=5 ns).
- R4: Read data is sampled on the edge that ends the read strobe window. It appears on `rd_data` with `rd_valid` high for exactly one clock, and the value equals the byte most recently written to that address (0x00 if the address was never written).
- R5: A write holds chip select and write strobe low and the read strobe high for PW_CYC clocks, starting at the clock after acceptance, with `sram_dq_oe` high and `sram_dq_out` equal to the accepted byte. PW_CYC is the largest of ceil(50/P), ceil(60/P) and ceil(30/P) (12 at P=5 ns).
- R6: After a write pulse, all strobes are high and `sram_dq_oe` is low for REC_CYC = max(1, ceil(70/P) - PW_CYC) clocks (2 at P=5 ns) before the controller is idle again.
- R7: After a read, all strobes are high and the driver is off for HZ_CYC = ceil(25/P) clocks (5 at P=5 ns) before the controller is idle again. `sram_dq_oe` is never high while the read strobe is low, and the two strobes are never low together.
- R8: `sram_addr` holds the accepted address from the accepting edge until the end of the access. Changes on the request fields while the controller is busy have no effect.
- R9: A byte written through the controller is stored at its address in the memory and is returned by a later read of that address. Writes to the lowest and highest addresses (0x0000 and 0x7FFF) do this too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse, rd_data is new |
| rd_data | output | 8 | Last captured read byte |
| sram_addr | output | 15 | Memory address bus |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory read strobe, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_dq_out | output | 8 | Outgoing data byte |
| sram_dq_oe | output | 1 | Data driver enable |
| sram_dq_in | input | 8 | Incoming data byte from the memory pins |

## Verification
The assertions assume a synchronous reset that is applied before any request. They also assume the host follows the valid/ready rule and holds its fields steady only up to the accepting edge, which is all the controller relies on. The stimulus changes fields only on falling edges. It keeps `req_valid` high across busy periods, so that ready is tested under pressure, and it scrambles address and data right after each acceptance to show they are ignored. The memory model in the bench drives its bus only in the read state, so any overlap with the controller's driver is caught as contention.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_ACC = 3'd1,
    ST_RD_FLT = 3'd2,
    ST_WR_PLS = 3'd3,
    ST_WR_REC = 3'd4
  } seq_state_t;

  // Nanoseconds to clocks, rounded up, at least one clock.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 4,
  parameter int RD_CYC  = 14,
  parameter int PW_CYC  = 12,
  parameter int REC_CYC = 2,
  parameter int HZ_CYC  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              cap_en,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe
);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] PW_LD  = CNT_W'(PW_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LD  = CNT_W'(HZ_CYC - 1);

  seq_state_t state, nxt;
  logic       accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_en   = 1'b0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        nxt      = req_write ? ST_WR_PLS : ST_RD_ACC;
        tmr_load = 1'b1;
        tmr_val  = req_write ? PW_LD : RD_LD;
      end
      ST_RD_ACC: if (tmr_done) begin
        nxt      = ST_RD_FLT;
        tmr_load = 1'b1;
        tmr_val  = HZ_LD;
        cap_en   = 1'b1;
      end
      ST_RD_FLT: if (tmr_done) nxt = ST_IDLE;
      ST_WR_PLS: if (tmr_done) begin
        nxt      = ST_WR_REC;
        tmr_load = 1'b1;
        tmr_val  = REC_LD;
      end
      ST_WR_REC: if (tmr_done) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state so the pins are glitch free.
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      sram_ce_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_dq_oe  <= 1'b0;
      sram_addr   <= '0;
      sram_dq_out <= '0;
    end else begin
      state      <= nxt;
      sram_ce_n  <= !((nxt == ST_RD_ACC) || (nxt == ST_WR_PLS));
      sram_oe_n  <= (nxt != ST_RD_ACC);
      sram_we_n  <= (nxt != ST_WR_PLS);
      sram_dq_oe <= (nxt == ST_WR_PLS);
      if (accept) begin
        sram_addr   <= req_addr;
        sram_dq_out <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 5,
  parameter int T_RC_NS   = 70,
  parameter int T_AA_NS   = 70,
  parameter int T_DOE_NS  = 35,
  parameter int T_PWE_NS  = 50,
  parameter int T_AW_NS   = 60,
  parameter int T_SD_NS   = 30,
  parameter int T_WC_NS   = 70,
  parameter int T_HZ_NS   = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int RD_CYC  = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int PW_CYC  = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                ns_to_cyc(T_SD_NS, CLK_NS));
  localparam int REC_CYC = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - PW_CYC);
  localparam int HZ_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC = imax(imax(RD_CYC, PW_CYC), imax(REC_CYC, HZ_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_done, cap_en;
  logic [CNT_W-1:0] tmr_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  sram_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .RD_CYC(RD_CYC), .PW_CYC(PW_CYC), .REC_CYC(REC_CYC), .HZ_CYC(HZ_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val), .cap_en(cap_en),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .capture(cap_en), .dq_in(sram_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/sram_ctrl_checks.sv
module sram_ctrl_checks #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rd_valid));

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (rst)
    !sram_ce_n |-> !req_ready);

  p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_write_drives_r5: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (sram_dq_oe && !sram_ce_n));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> sram_oe_n);

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(!sram_oe_n && !sram_we_n));

  p_addr_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));
endmodule

bind sram_async_ctrl sram_ctrl_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
  .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
  .sram_we_n(sram_we_n), .sram_dq_oe(sram_dq_oe)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
  localparam int P   = 5;
  localparam int RD  = (70 + P - 1) / P;                 // R3
  localparam int PW  = (60 + P - 1) / P;                 // R5: 60 ns dominates
  localparam int REC = (((70 + P - 1) / P) - PW) < 1 ? 1 : (((70 + P - 1) / P) - PW); // R6
  localparam int HZ  = (25 + P - 1) / P;                 // R7
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0]  rd_data, sram_dq_out;
  logic [7:0]  sram_dq_in = 8'hEE;
  logic [14:0] sram_addr;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  sram_async_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model (behavioural, per clock) ----------------
  int         mode = 0;   // 0 idle, 1 read, 2 read float, 3 write, 4 write recovery
  int         rem  = 0;
  logic [14:0] m_addr = '0;
  logic [7:0]  m_wdata = '0;
  bit          m_rvalid = 0;
  logic [7:0]  m_rdata = '0;
  bit          started = 0;
  logic [7:0]  ref_mem [int];

  function automatic logic [7:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mode = 0; rem = 0; m_rvalid = 0;
    end else begin
      started = 1;
      m_rvalid = 0;
      case (mode)
        0: if (req_valid) begin
          m_addr = req_addr; m_wdata = req_wdata;
          if (req_write) begin mode = 3; rem = PW; ref_mem[int'(req_addr)] = req_wdata; end
          else begin mode = 1; rem = RD; end
        end
        1: if (rem == 1) begin
          m_rvalid = 1; m_rdata = ref_rd(int'(m_addr)); mode = 2; rem = HZ;
        end else rem--;
        2: if (rem == 1) mode = 0; else rem--;
        3: if (rem == 1) begin mode = 4; rem = REC; end else rem--;
        4: if (rem == 1) mode = 0; else rem--;
        default: mode = 0;
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst && started) begin
      string tag;
      bit e_ce, e_oe, e_we, e_doe;
      case (mode)
        1: tag = "R3"; 2: tag = "R7"; 3: tag = "R5"; 4: tag = "R6"; default: tag = "R2";
      endcase
      e_ce  = !(mode == 1 || mode == 3);
      e_oe  = (mode != 1);
      e_we  = (mode != 3);
      e_doe = (mode == 3);
      chk(req_ready == (mode == 0), "R2", "req_ready", req_ready, mode == 0);
      chk(sram_ce_n == e_ce, tag, "ce_n", sram_ce_n, e_ce);
      chk(sram_oe_n == e_oe, tag, "oe_n", sram_oe_n, e_oe);
      chk(sram_we_n == e_we, tag, "we_n", sram_we_n, e_we);
      chk(sram_dq_oe == e_doe, tag, "dq_oe", sram_dq_oe, e_doe);
      chk(rd_valid == m_rvalid, "R4", "rd_valid", rd_valid, m_rvalid);
      if (m_rvalid) chk(rd_data == m_rdata, "R4", "rd_data", rd_data, m_rdata);
      if (mode != 0) chk(sram_addr == m_addr, "R8", "sram_addr", sram_addr, m_addr);
      if (mode == 3) chk(sram_dq_out == m_wdata, "R5", "dq_out", sram_dq_out, m_wdata);
    end
  end

  // ---------------- asynchronous memory model ----------------
  logic [7:0]  smem [int];
  bit          prev_wr = 0;
  logic [14:0] p_addr = '0;
  logic [7:0]  p_data = '0;

  always @(negedge clk) begin
    bit cur_wr, drv;
    cur_wr = !sram_ce_n && !sram_we_n;
    drv    = !sram_ce_n && !sram_oe_n && sram_we_n;
    if (prev_wr && !cur_wr) smem[int'(p_addr)] = p_data;
    prev_wr = cur_wr; p_addr = sram_addr; p_data = sram_dq_out;
    if (!rst && started) chk(!(drv && sram_dq_oe), "R7", "bus contention", 1, 0);
    sram_dq_in = drv ? (smem.exists(int'(sram_addr)) ? smem[int'(sram_addr)] : 8'h00) : 8'hEE;
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);                    // accepted on the edge just passed
    req_valid = 0; req_addr = ~a; req_wdata = ~d; req_write = ~w;  // R8: ignored
    while (!req_ready) @(negedge clk);
  endtask

  // Back-to-back: valid held high across the busy period (R2).
  task automatic issue_pair(input bit w0, input logic [14:0] a0, input logic [7:0] d0,
                            input bit w1, input logic [14:0] a1, input logic [7:0] d1);
    @(negedge clk);
    req_valid = 1; req_write = w0; req_addr = a0; req_wdata = d0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_write = w1; req_addr = a1; req_wdata = d1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(sram_ce_n && sram_oe_n && sram_we_n, "R1", "strobes in reset",
            {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
        rst = 0;
        @(negedge clk);
        chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rd_valid && req_ready,
            "R1", "state after reset",
            {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, rd_valid, req_ready}, 6'b111001);
        // R9: corner addresses and patterns
        issue(1, 15'h0000, 8'hA5);
        issue(1, 15'h7FFF, 8'h3C);
        issue(1, 15'h1234, 8'hFF);
        issue(0, 15'h0000, 8'h00);
        issue(0, 15'h7FFF, 8'h00);
        issue(0, 15'h1234, 8'h00);
        issue(0, 15'h0100, 8'h00);    // never written: 0x00
        // overwrite then immediate read, read then write, write then write
        issue_pair(1, 15'h1234, 8'h5A, 0, 15'h1234, 8'h00);
        issue_pair(0, 15'h7FFF, 8'h00, 1, 15'h7FFF, 8'h81);
        issue_pair(1, 15'h0042, 8'h01, 1, 15'h0043, 8'h02);
        issue_pair(0, 15'h0042, 8'h00, 0, 15'h0043, 8'h00);
        issue(0, 15'h7FFF, 8'h00);
        // mixed sweep
        for (int i = 0; i < 24; i++) begin
          logic [14:0] a;
          a = 15'((i * 1237 + 91) & 16'h7FFF);
          issue(1, a, 8'(i * 29 + 7));
          if (i % 3 == 0) repeat (i % 5) @(negedge clk);
        end
        for (int i = 0; i < 24; i++) issue(0, 15'((i * 1237 + 91) & 16'h7FFF), 8'h00);
        repeat (5) @(negedge clk);
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; failures++;
        $display("FAIL R2 watchdog expired act=%0d exp=%0d", WATCHDOG, 0);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule